// File: doc/BRIEF.md
# Performance-Level Clock Configuration Selector

This block sits in front of a clock root divider and picks which divider settings it receives. It holds eight performance levels. Each level has its own source select, pre-divider and mode word, and its own M and N values. A register port writes these level banks and reads them back.

When dynamic scaling is turned on, a hardware level input indexes the bank, and the chosen level's settings go to the divider. When scaling is off, the divider receives the normal configuration fields, which arrive on separate inputs. In both cases the control register reports the level that was last sampled from the level input.

All divider controls are registered. Whenever the source of those controls changes, the block raises a single-cycle update strobe in the same cycle that the new values appear. The source changes when a different level is selected while scaling is on, or when scaling is switched on or off.

Top module: `dfs_level_sel`

## Requirements
- R1: While reset is held, every divider output and `div_update` is 0, and the control register (byte address 0x14) reads 0.
- R2: The level-l configuration word is at byte address 0x1C+4·l. It reads back the pre-divider in bits 4:0, the source in bits 10:8 and the mode in bits 13:12; all other bits read 0 whatever was written. The level-l M value (0x5C+4·l) and N value (0x9C+4·l) read back in bits 7:0 with zeros above.
- R3: In the control register, bit 0 is the scaling enable and can be written and read. Bits 4:1 read the level input as sampled at the previous clock edge. A write to bits 4:1 has no effect, and all other bits read 0.
- R4: With scaling enabled, the clock edge after `level_in` changes puts that level's source, mode and M value on the divider outputs.
- R5: With scaling enabled, a level pre-divider of 0 is driven on `div_pre` as 1; any other value is driven unchanged.
- R6: N is stored as the bitwise inverse of (N−M). `div_n` is (~stored + M) modulo 256. When the active mode is 0, `div_m` and `div_n` are both 0. This holds on both the level path and the normal path.
- R7: With scaling disabled, the divider outputs follow the `base_*` inputs one clock later, and `level_in` has no effect on them.
- R8: `div_update` is high for exactly one cycle in two cases: when outputs switch because of a level change while enabled, and when an enable change takes effect. A level change while disabled produces no pulse.
- R9: Writes to unmapped or misaligned addresses change nothing, and reads of those addresses return 0.
- R10: Rewriting the bank of the active level while enabled changes the outputs at the next edge without an update pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| level_in | input | 3 | Requested performance level |
| base_pre | input | 5 | Normal-path pre-divider |
| base_src | input | 3 | Normal-path source select |
| base_mode | input | 2 | Normal-path mode |
| base_m | input | 8 | Normal-path M value |
| base_n | input | 8 | Normal-path N value, inverted (N−M) encoding |
| div_pre | output | 5 | Pre-divider to divider |
| div_src | output | 3 | Source select to divider |
| div_mode | output | 2 | Mode to divider |
| div_m | output | 8 | M to divider |
| div_n | output | 8 | Decoded N to divider |
| div_update | output | 1 | One-cycle strobe when the control source switches |

## Verification
The bound checker watches several behaviours on every cycle. It checks that the status level always lags the level input by one edge, that the disabled path forwards the normal source, that no zero pre-divider ever leaves the block in scaling mode, that M and N stay zero whenever the mode is zero, and that an enabled level change is always followed by a strobe. Other behaviours can only be shown by the bench scenarios: the per-level bank contents reaching the outputs, the N decoding arithmetic, register readback with masked bits, unmapped-address writes that do nothing, the absence of a pulse on a same-level bank rewrite, and the pulse when enable toggles.

// File: rtl/dfs_lvl_pkg.sv
package dfs_lvl_pkg;
  localparam int SRC_LSB  = 8;
  localparam int SRC_W    = 3;
  localparam int MODE_LSB = 12;
  localparam int MODE_W   = 2;
  localparam int STRIDE   = 4;
  localparam int CTRL_OFS = 'h14;
  localparam int CFG_BASE = 'h1C;
  localparam int M_BASE   = 'h5C;
  localparam int N_BASE   = 'h9C;
  localparam int STAT_W   = 4;

  typedef enum logic [2:0] {
    REG_NONE,
    REG_CTRL,
    REG_CFG,
    REG_M,
    REG_N
  } reg_kind_e;
endpackage

// File: rtl/dfs_lvl_bank.sv
module dfs_lvl_bank #(
  parameter int NUM_LVL = 8,
  parameter int DIV_W   = 5,
  parameter int MND_W   = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_LVL-1:0]            cfg_we,
  input  logic [NUM_LVL-1:0]            m_we,
  input  logic [NUM_LVL-1:0]            n_we,
  input  logic [DIV_W-1:0]              wr_div,
  input  logic [dfs_lvl_pkg::SRC_W-1:0] wr_src,
  input  logic [dfs_lvl_pkg::MODE_W-1:0] wr_mode,
  input  logic [MND_W-1:0]              wr_mnd,
  output logic [DIV_W-1:0]              b_div  [NUM_LVL],
  output logic [dfs_lvl_pkg::SRC_W-1:0] b_src  [NUM_LVL],
  output logic [dfs_lvl_pkg::MODE_W-1:0] b_mode [NUM_LVL],
  output logic [MND_W-1:0]              b_m    [NUM_LVL],
  output logic [MND_W-1:0]              b_n    [NUM_LVL]
);
  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        b_div[g]  <= '0;
        b_src[g]  <= '0;
        b_mode[g] <= '0;
      end else if (cfg_we[g]) begin
        b_div[g]  <= wr_div;
        b_src[g]  <= wr_src;
        b_mode[g] <= wr_mode;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        b_m[g] <= '0;
      else if (m_we[g])  b_m[g] <= wr_mnd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        b_n[g] <= '0;
      else if (n_we[g])  b_n[g] <= wr_mnd;
    end
  end
endmodule

// File: rtl/dfs_lvl_regif.sv
module dfs_lvl_regif
  import dfs_lvl_pkg::*;
#(
  parameter int NUM_LVL = 8,
  parameter int ADDR_W  = 8,
  parameter int DIV_W   = 5,
  parameter int MND_W   = 8,
  parameter int LVL_W   = $clog2(NUM_LVL)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [LVL_W-1:0]   level_in,
  input  logic [DIV_W-1:0]   b_div  [NUM_LVL],
  input  logic [SRC_W-1:0]   b_src  [NUM_LVL],
  input  logic [MODE_W-1:0]  b_mode [NUM_LVL],
  input  logic [MND_W-1:0]   b_m    [NUM_LVL],
  input  logic [MND_W-1:0]   b_n    [NUM_LVL],
  output logic               en_q,
  output logic [LVL_W-1:0]   lvl_q,
  output logic [NUM_LVL-1:0] cfg_we,
  output logic [NUM_LVL-1:0] m_we,
  output logic [NUM_LVL-1:0] n_we,
  output logic [DIV_W-1:0]   wr_div,
  output logic [SRC_W-1:0]   wr_src,
  output logic [MODE_W-1:0]  wr_mode,
  output logic [MND_W-1:0]   wr_mnd
);
  localparam int SPAN = STRIDE * NUM_LVL;

  reg_kind_e        kind;
  int               a;
  int               idx;
  logic [LVL_W-1:0] idx_l;
  logic             unused_wdata;

  always_comb begin
    kind = REG_NONE;
    idx  = 0;
    a    = int'(bus_addr);
    if (a % STRIDE == 0) begin
      if (a == CTRL_OFS) begin
        kind = REG_CTRL;
      end else if (a >= CFG_BASE && a < CFG_BASE + SPAN) begin
        kind = REG_CFG;
        idx  = (a - CFG_BASE) / STRIDE;
      end else if (a >= M_BASE && a < M_BASE + SPAN) begin
        kind = REG_M;
        idx  = (a - M_BASE) / STRIDE;
      end else if (a >= N_BASE && a < N_BASE + SPAN) begin
        kind = REG_N;
        idx  = (a - N_BASE) / STRIDE;
      end
    end
  end

  assign idx_l   = LVL_W'(idx);
  assign wr_div  = bus_wdata[DIV_W-1:0];
  assign wr_src  = bus_wdata[SRC_LSB +: SRC_W];
  assign wr_mode = bus_wdata[MODE_LSB +: MODE_W];
  assign wr_mnd  = bus_wdata[MND_W-1:0];
  assign unused_wdata = ^bus_wdata;

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_we
    assign cfg_we[g] = bus_wr && (kind == REG_CFG) && (idx_l == LVL_W'(g));
    assign m_we[g]   = bus_wr && (kind == REG_M)   && (idx_l == LVL_W'(g));
    assign n_we[g]   = bus_wr && (kind == REG_N)   && (idx_l == LVL_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      lvl_q <= '0;
    end else begin
      lvl_q <= level_in;
      if (bus_wr && kind == REG_CTRL) en_q <= bus_wdata[0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (kind)
      REG_CTRL: begin
        bus_rdata[0]        = en_q;
        bus_rdata[STAT_W:1] = STAT_W'(lvl_q);
      end
      REG_CFG: begin
        bus_rdata[DIV_W-1:0]         = b_div[idx_l];
        bus_rdata[SRC_LSB +: SRC_W]  = b_src[idx_l];
        bus_rdata[MODE_LSB +: MODE_W] = b_mode[idx_l];
      end
      REG_M:   bus_rdata[MND_W-1:0] = b_m[idx_l];
      REG_N:   bus_rdata[MND_W-1:0] = b_n[idx_l];
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dfs_lvl_outmux.sv
module dfs_lvl_outmux
  import dfs_lvl_pkg::*;
#(
  parameter int NUM_LVL = 8,
  parameter int DIV_W   = 5,
  parameter int MND_W   = 8,
  parameter int LVL_W   = $clog2(NUM_LVL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_q,
  input  logic [LVL_W-1:0]  lvl_q,
  input  logic [LVL_W-1:0]  level_in,
  input  logic [DIV_W-1:0]  b_div  [NUM_LVL],
  input  logic [SRC_W-1:0]  b_src  [NUM_LVL],
  input  logic [MODE_W-1:0] b_mode [NUM_LVL],
  input  logic [MND_W-1:0]  b_m    [NUM_LVL],
  input  logic [MND_W-1:0]  b_n    [NUM_LVL],
  input  logic [DIV_W-1:0]  base_pre,
  input  logic [SRC_W-1:0]  base_src,
  input  logic [MODE_W-1:0] base_mode,
  input  logic [MND_W-1:0]  base_m,
  input  logic [MND_W-1:0]  base_n,
  output logic [DIV_W-1:0]  div_pre,
  output logic [SRC_W-1:0]  div_src,
  output logic [MODE_W-1:0] div_mode,
  output logic [MND_W-1:0]  div_m,
  output logic [MND_W-1:0]  div_n,
  output logic              div_update,
  output logic              lvl_switch,
  output logic              en_switch
);
  function automatic logic [MND_W-1:0] decode_n(input logic [MND_W-1:0] m,
                                                input logic [MND_W-1:0] nraw);
    return MND_W'(~nraw + m);
  endfunction

  function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] d);
    return (d == '0) ? DIV_W'(1) : d;
  endfunction

  logic              en_dly;
  logic [DIV_W-1:0]  pre_nx;
  logic [SRC_W-1:0]  src_nx;
  logic [MODE_W-1:0] mode_nx;
  logic [MND_W-1:0]  m_raw, n_raw;

  always_comb begin
    if (en_q) begin
      pre_nx  = eff_div(b_div[level_in]);
      src_nx  = b_src[level_in];
      mode_nx = b_mode[level_in];
      m_raw   = b_m[level_in];
      n_raw   = b_n[level_in];
    end else begin
      pre_nx  = base_pre;
      src_nx  = base_src;
      mode_nx = base_mode;
      m_raw   = base_m;
      n_raw   = base_n;
    end
  end

  assign lvl_switch = en_q && (level_in != lvl_q);
  assign en_switch  = en_q != en_dly;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_pre    <= '0;
      div_src    <= '0;
      div_mode   <= '0;
      div_m      <= '0;
      div_n      <= '0;
      div_update <= 1'b0;
      en_dly     <= 1'b0;
    end else begin
      div_pre    <= pre_nx;
      div_src    <= src_nx;
      div_mode   <= mode_nx;
      div_m      <= (mode_nx != '0) ? m_raw : '0;
      div_n      <= (mode_nx != '0) ? decode_n(m_raw, n_raw) : '0;
      div_update <= lvl_switch || en_switch;
      en_dly     <= en_q;
    end
  end
endmodule

// File: rtl/dfs_level_sel.sv
module dfs_level_sel
  import dfs_lvl_pkg::*;
#(
  parameter int NUM_LVL = 8,
  parameter int ADDR_W  = 8,
  parameter int DIV_W   = 5,
  parameter int MND_W   = 8,
  parameter int LVL_W   = $clog2(NUM_LVL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [LVL_W-1:0]  level_in,
  input  logic [DIV_W-1:0]  base_pre,
  input  logic [SRC_W-1:0]  base_src,
  input  logic [MODE_W-1:0] base_mode,
  input  logic [MND_W-1:0]  base_m,
  input  logic [MND_W-1:0]  base_n,
  output logic [DIV_W-1:0]  div_pre,
  output logic [SRC_W-1:0]  div_src,
  output logic [MODE_W-1:0] div_mode,
  output logic [MND_W-1:0]  div_m,
  output logic [MND_W-1:0]  div_n,
  output logic              div_update
);
  logic [DIV_W-1:0]   b_div  [NUM_LVL];
  logic [SRC_W-1:0]   b_src  [NUM_LVL];
  logic [MODE_W-1:0]  b_mode [NUM_LVL];
  logic [MND_W-1:0]   b_m    [NUM_LVL];
  logic [MND_W-1:0]   b_n    [NUM_LVL];
  logic               en_q;
  logic [LVL_W-1:0]   lvl_q;
  logic [NUM_LVL-1:0] cfg_we, m_we, n_we;
  logic [DIV_W-1:0]   wr_div;
  logic [SRC_W-1:0]   wr_src;
  logic [MODE_W-1:0]  wr_mode;
  logic [MND_W-1:0]   wr_mnd;
  logic               lvl_switch, en_switch;

  dfs_lvl_regif #(.NUM_LVL(NUM_LVL), .ADDR_W(ADDR_W), .DIV_W(DIV_W),
                  .MND_W(MND_W), .LVL_W(LVL_W)) u_regif (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .level_in(level_in),
    .b_div(b_div), .b_src(b_src), .b_mode(b_mode), .b_m(b_m), .b_n(b_n),
    .en_q(en_q), .lvl_q(lvl_q), .cfg_we(cfg_we), .m_we(m_we), .n_we(n_we),
    .wr_div(wr_div), .wr_src(wr_src), .wr_mode(wr_mode), .wr_mnd(wr_mnd)
  );

  dfs_lvl_bank #(.NUM_LVL(NUM_LVL), .DIV_W(DIV_W), .MND_W(MND_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .m_we(m_we), .n_we(n_we),
    .wr_div(wr_div), .wr_src(wr_src), .wr_mode(wr_mode), .wr_mnd(wr_mnd),
    .b_div(b_div), .b_src(b_src), .b_mode(b_mode), .b_m(b_m), .b_n(b_n)
  );

  dfs_lvl_outmux #(.NUM_LVL(NUM_LVL), .DIV_W(DIV_W), .MND_W(MND_W),
                   .LVL_W(LVL_W)) u_outmux (
    .clk(clk), .rst_n(rst_n), .en_q(en_q), .lvl_q(lvl_q), .level_in(level_in),
    .b_div(b_div), .b_src(b_src), .b_mode(b_mode), .b_m(b_m), .b_n(b_n),
    .base_pre(base_pre), .base_src(base_src), .base_mode(base_mode),
    .base_m(base_m), .base_n(base_n),
    .div_pre(div_pre), .div_src(div_src), .div_mode(div_mode),
    .div_m(div_m), .div_n(div_n), .div_update(div_update),
    .lvl_switch(lvl_switch), .en_switch(en_switch)
  );
endmodule

// File: rtl/dfs_level_sel_chk.sv
module dfs_level_sel_chk #(
  parameter int DIV_W = 5,
  parameter int MND_W = 8,
  parameter int LVL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_q,
  input logic [LVL_W-1:0] lvl_q,
  input logic [LVL_W-1:0] level_in,
  input logic [2:0]       base_src,
  input logic [DIV_W-1:0] div_pre,
  input logic [2:0]       div_src,
  input logic [1:0]       div_mode,
  input logic [MND_W-1:0] div_m,
  input logic [MND_W-1:0] div_n,
  input logic             div_update
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R3
  status_lag_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    lvl_q == $past(level_in));

  // R7
  base_src_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !$past(en_q) |-> div_src == $past(base_src));

  // R5
  no_zero_pre_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(en_q) |-> div_pre != '0);

  // R6
  mnd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_mode == 2'd0 |-> (div_m == '0 && div_n == '0));

  // R8
  lvl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && level_in != lvl_q) |=> div_update);
endmodule

bind dfs_level_sel dfs_level_sel_chk #(.DIV_W(DIV_W), .MND_W(MND_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .lvl_q(lvl_q), .level_in(level_in),
  .base_src(base_src), .div_pre(div_pre), .div_src(div_src),
  .div_mode(div_mode), .div_m(div_m), .div_n(div_n), .div_update(div_update)
);

// File: tb/dfs_level_sel_tb.sv
module dfs_level_sel_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  level_in = '0;
  logic [4:0]  base_pre = '0;
  logic [2:0]  base_src = '0;
  logic [1:0]  base_mode = '0;
  logic [7:0]  base_m = '0;
  logic [7:0]  base_n = '0;
  logic [4:0]  div_pre;
  logic [2:0]  div_src;
  logic [1:0]  div_mode;
  logic [7:0]  div_m;
  logic [7:0]  div_n;
  logic        div_update;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dfs_level_sel u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .level_in(level_in),
    .base_pre(base_pre), .base_src(base_src), .base_mode(base_mode),
    .base_m(base_m), .base_n(base_n), .div_pre(div_pre), .div_src(div_src),
    .div_mode(div_mode), .div_m(div_m), .div_n(div_n), .div_update(div_update)
  );

  typedef struct packed {
    logic [2:0] lvl;
    logic       upd;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{3'd5, 1'b0}, '{3'd2, 1'b1}, '{3'd2, 1'b0}, '{3'd7, 1'b1}, '{3'd0, 1'b1},
    '{3'd3, 1'b1}, '{3'd3, 1'b0}, '{3'd6, 1'b1}, '{3'd1, 1'b1}, '{3'd4, 1'b1}
  };

  // bench-side description of what each level bank holds
  function automatic logic [4:0] m_div(int l);  return (l == 2) ? 5'd0 : 5'(l + 3); endfunction
  function automatic logic [2:0] m_src(int l);  return 3'(7 - l); endfunction
  function automatic logic [1:0] m_mode(int l); return 2'(l % 3); endfunction
  function automatic logic [7:0] m_mval(int l); return 8'(10 + l); endfunction
  function automatic logic [7:0] m_nval(int l); return 8'(40 + 5 * l); endfunction
  function automatic logic [7:0] m_nraw(int l); return ~(m_nval(l) - m_mval(l)); endfunction
  function automatic logic [31:0] m_word(int l);
    return {18'd0, m_mode(l), 1'b0, m_src(l), 3'd0, m_div(l)};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic check_level(string tag, int l);
    logic [1:0] md;
    md = m_mode(l);
    check({tag, " pre"},  32'(div_pre),  (m_div(l) == 0) ? 32'd1 : 32'(m_div(l)));
    check({tag, " src"},  32'(div_src),  32'(m_src(l)));
    check({tag, " mode"}, 32'(div_mode), 32'(md));
    check({tag, " m"},    32'(div_m),    (md != 0) ? 32'(m_mval(l)) : 32'd0);
    check({tag, " n"},    32'(div_n),    (md != 0) ? 32'(m_nval(l)) : 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int prev;
    tick(); tick();
    // R1 reset state
    rd(8'h14, d);
    check("R1 ctrl", d, 32'd0);
    check("R1 outs", {div_pre, div_src, div_mode, div_m, div_n, div_update}, 32'd0);
    @(posedge clk); #2 rst_n = 1'b1;
    tick();

    // R7 normal path
    base_pre = 5'd5; base_src = 3'd3; base_mode = 2'd2; base_m = 8'd7; base_n = ~8'd13;
    tick();
    check("R7 pre", 32'(div_pre), 32'd5);
    check("R7 src", 32'(div_src), 32'd3);
    check("R6 base m", 32'(div_m), 32'd7);
    check("R6 base n", 32'(div_n), 32'd20);
    level_in = 3'd5;
    tick();
    check("R7 level ignored", 32'(div_src), 32'd3);
    check("R8 no pulse when disabled", 32'(div_update), 32'd0);
    rd(8'h14, d);
    check("R3 status while disabled", d, 32'h0000_000A);
    base_mode = 2'd0;
    tick();
    check("R6 base mode0", {24'd0, div_m | div_n}, 32'd0);
    base_mode = 2'd2;

    // R2 bank programming and masked readback
    for (int l = 0; l < 8; l++) begin
      wr(8'(8'h1C + 4 * l), m_word(l) | 32'hFFFF_C8E0);
      wr(8'(8'h5C + 4 * l), 32'hFFFF_FF00 | 32'(m_mval(l)));
      wr(8'(8'h9C + 4 * l), 32'hFFFF_FF00 | 32'(m_nraw(l)));
    end
    for (int l = 0; l < 8; l++) begin
      rd(8'(8'h1C + 4 * l), d); check("R2 cfg", d, m_word(l));
      rd(8'(8'h5C + 4 * l), d); check("R2 m", d, 32'(m_mval(l)));
      rd(8'(8'h9C + 4 * l), d); check("R2 n", d, 32'(m_nraw(l)));
    end

    // R9 unmapped and misaligned
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h1E, 32'h0000_0000);
    wr(8'hDC, 32'hFFFF_FFFF);
    rd(8'h18, d); check("R9 read 0x18", d, 32'd0);
    rd(8'hDC, d); check("R9 read 0xDC", d, 32'd0);
    rd(8'h00, d); check("R9 read 0x00", d, 32'd0);
    rd(8'h1C, d); check("R9 level0 intact", d, m_word(0));
    rd(8'h14, d); check("R9 ctrl intact", d, 32'h0000_000A);

    // R3 enable write; level bits not writable
    wr(8'h14, 32'h0000_001F);
    rd(8'h14, d); check("R3 ctrl after write", d, 32'h0000_000B);
    tick();
    check("R8 pulse on enable", 32'(div_update), 32'd1);
    check_level("R4 enable level5", 5);
    tick();
    check("R8 pulse one cycle", 32'(div_update), 32'd0);

    // R4/R5/R6/R8 table walk
    prev = 5;
    foreach (VECS[i]) begin
      level_in = VECS[i].lvl;
      tick();
      check_level("R4 table", int'(VECS[i].lvl));
      check("R8 table pulse", 32'(div_update), 32'(VECS[i].upd));
      rd(8'h14, d);
      check("R3 table status", d, {27'd0, 1'b0, VECS[i].lvl, 1'b1});
      prev = int'(VECS[i].lvl);
    end
    check("R5 zero prediv via level2", 32'(m_div(2)), 32'd0);

    // R10 rewrite active bank (level 4)
    wr(8'h2C, 32'h0000_2609);
    tick();
    check("R10 pre", 32'(div_pre), 32'd9);
    check("R10 src", 32'(div_src), 32'd6);
    check("R10 no pulse", 32'(div_update), 32'd0);

    // R8/R7 disable
    wr(8'h14, 32'h0);
    tick();
    check("R8 pulse on disable", 32'(div_update), 32'd1);
    check("R7 back to base", 32'(div_pre), 32'd5);
    check("R7 base src", 32'(div_src), 32'd3);
    tick();
    check("R8 disable pulse clears", 32'(div_update), 32'd0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule